// File: doc/BRIEF.md
# UART and Interrupt Register Block

This block is a small peripheral register file that sits on a simple 32-bit CPU load/store bus. It holds three registers at fixed addresses. The first is a UART data register: it returns the last received byte and passes written bytes on to a transmitter. The second is an interrupt enable mask. The third is an interrupt status word. The UART serializer, the free-running counter and general memory all live outside the block. The block only recognizes its own three addresses. A read of any other address returns zero, and a write to any other address changes nothing.

The status word tracks four sources. Bit 0 means a received byte is waiting. Bit 1 means the transmitter is ready. Bit 2 is the inverse of one tap of an external free-running counter, and bit 3 is that tap itself. The block has side effects on the bus:

- A read of the data register consumes the byte, which clears bit 0.
- Any read at all marks the transmitter ready, which sets bit 1.
- Software may overwrite the status word and the mask.

One registered interrupt request line is high whenever the status and the mask share a set bit.

Top module: `uart_irq_regs`

## Requirements
- R1: After reset the mask, status, received-byte and transmit registers are zero, and the interrupt line and transmit strobe are low. Status bits 2/3 start to follow the counter on the first clock after reset.
- R2: A receive strobe latches `rx_byte` into the data register and sets status bit 0 (value 0x01). A read of address 0x20000000 returns the byte zero-extended.
- R3: A read of address 0x20000000 clears status bit 0. If a new byte arrives in the same cycle, the arrival wins: bit 0 stays set and the new byte is stored, while the read returns the old byte.
- R4: Any bus read, mapped or not, sets status bit 1 (value 0x02) from the next cycle on.
- R5: Status bit 2 (0x04) equals the inverse and bit 3 (0x08) equals the value of counter bit 18, as sampled on the previous clock. These bits override any value software writes to them.
- R6: A write to 0x20000010 replaces the whole mask, and a write to 0x20000020 replaces the whole status word (bits 2/3 excepted, see R5). Reads of these addresses return the stored value zero-extended.
- R7: A write to 0x20000000 places the low 8 data bits on `tx_byte` and raises `tx_valid` for exactly one cycle, starting on the cycle after the write.
- R8: `irq` is a register that, on each clock, takes the OR-reduction of (status AND mask). It therefore rises or falls one cycle after the status/mask condition changes.
- R9: Reads of any address other than the three registers return zero. Writes to other addresses leave the mask, status and data registers unchanged.
- R10: When read and write strobes are both high in one cycle, only the write is performed. Status bits 0 and 1 see no read side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, zero when no read |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_byte | output | 8 | Byte to transmit |
| cnt_in | input | 32 | Free-running counter value |
| irq | output | 1 | Interrupt request |

## Verification
The in-RTL assertions check the following relations on every cycle:

- the receive-set and read-clear rules for bit 0;
- the read-set rule for bit 1;
- the counter tracking of bits 2/3;
- the one-cycle transmit strobe and its byte;
- the mask load;
- zero data on unmapped reads;
- the write-only handling of combined strobes;
- the registered interrupt equation.

Some behaviours can only be shown by the bench's scenarios:

- the reset values;
- the priority of a byte arriving during a data read, together with the old byte returned;
- the override of written bits 2/3;
- whole-word status writes;
- the full latency chain from a received byte to the interrupt line and back down after the byte is read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   // which register an access targets
   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_DATA   = 2'd1,
      SEL_MASK   = 2'd2,
      SEL_STATUS = 2'd3
   } reg_sel_e;

   // decoded bus access after read/write arbitration
   typedef struct packed {
      logic     rd;
      logic     wr;
      reg_sel_e sel;
   } bus_acc_t;

   // status bit positions (decoded by software, so fixed)
   localparam int unsigned ST_RX_AVAIL = 0;
   localparam int unsigned ST_TX_READY = 1;
   localparam int unsigned ST_TICK_N   = 2;
   localparam int unsigned ST_TICK     = 3;
   localparam int unsigned ST_MIN_W    = 4;

endpackage

// File: rtl/uart_irq_decode.sv
module uart_irq_decode import uart_irq_pkg::*; #(
   parameter int unsigned     ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 32'h2000_0000,
   parameter logic [ADDR_W-1:0] MASK_ADDR = 32'h2000_0010,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 32'h2000_0020
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   output bus_acc_t          acc
);

   if ((DATA_ADDR == MASK_ADDR) || (DATA_ADDR == STAT_ADDR) ||
       (MASK_ADDR == STAT_ADDR)) begin : g_bad_map
      $error("uart_irq_decode: register addresses must differ");
   end

   always_comb begin
      acc.wr = wr;
      acc.rd = rd & ~wr;        // write takes the cycle on a collision
      if (addr == DATA_ADDR)      acc.sel = SEL_DATA;
      else if (addr == MASK_ADDR) acc.sel = SEL_MASK;
      else if (addr == STAT_ADDR) acc.sel = SEL_STATUS;
      else                        acc.sel = SEL_NONE;
   end

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status import uart_irq_pkg::*; #(
   parameter int unsigned IRQ_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bus_acc_t         acc,
   input  logic [IRQ_W-1:0] wbits,
   input  logic             rx_strobe,
   input  logic             tick,
   output logic [IRQ_W-1:0] status_q
);

   if (IRQ_W < ST_MIN_W) begin : g_bad_w
      $error("uart_irq_status: IRQ_W must hold the four status sources");
   end

   logic [IRQ_W-1:0] status_d;

   always_comb begin
      status_d = status_q;
      if (acc.wr && (acc.sel == SEL_STATUS)) status_d = wbits;
      if (acc.rd)                            status_d[ST_TX_READY] = 1'b1;
      if (acc.rd && (acc.sel == SEL_DATA))   status_d[ST_RX_AVAIL] = 1'b0;
      if (rx_strobe)                         status_d[ST_RX_AVAIL] = 1'b1;
      status_d[ST_TICK_N] = ~tick;
      status_d[ST_TICK]   = tick;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= status_d;
   end

   AST_RX_SETS_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> status_q[ST_RX_AVAIL]); // R2
   AST_DATA_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.rd && acc.sel == SEL_DATA && !rx_strobe) |=> !status_q[ST_RX_AVAIL]); // R3
   AST_READ_SETS_TXRDY: assert property (@(posedge clk) disable iff (!rst_n)
      acc.rd |=> status_q[ST_TX_READY]); // R4
   AST_TICK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (status_q[ST_TICK] == $past(tick)) &&
               (status_q[ST_TICK_N] == !$past(tick))); // R5

endmodule

// File: rtl/uart_irq_req.sv
module uart_irq_req #(
   parameter int unsigned IRQ_W      = 8,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_W-1:0] status,
   input  logic [IRQ_W-1:0] mask,
   output logic             irq
);

   logic pending;
   assign pending = |(status & mask);

   if (REGISTERED) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pending;
      end
      assign irq = irq_q;

      AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> irq == |($past(status) & $past(mask))); // R8
   end else begin : g_comb
      assign irq = pending;
   end

endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs import uart_irq_pkg::*; #(
   parameter int unsigned       ADDR_W         = 32,
   parameter int unsigned       DATA_W         = 32,
   parameter int unsigned       BYTE_W         = 8,
   parameter int unsigned       IRQ_W          = 8,
   parameter int unsigned       CNT_W          = 32,
   parameter int unsigned       CNT_TAP        = 18,
   parameter bit                IRQ_REGISTERED = 1'b1,
   parameter logic [ADDR_W-1:0] DATA_ADDR      = 32'h2000_0000,
   parameter logic [ADDR_W-1:0] MASK_ADDR      = 32'h2000_0010,
   parameter logic [ADDR_W-1:0] STAT_ADDR      = 32'h2000_0020
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_byte,
   input  logic [CNT_W-1:0]  cnt_in,
   output logic              irq
);

   localparam int unsigned BYTE_PAD = DATA_W - BYTE_W;
   localparam int unsigned IRQ_PAD  = DATA_W - IRQ_W;

   if (BYTE_W >= DATA_W || IRQ_W >= DATA_W) begin : g_bad_width
      $error("uart_irq_regs: byte and irq widths must be below DATA_W");
   end
   if (CNT_TAP >= CNT_W) begin : g_bad_tap
      $error("uart_irq_regs: CNT_TAP outside counter");
   end

   bus_acc_t          acc;
   logic [IRQ_W-1:0]  status_q;
   logic [IRQ_W-1:0]  mask_q;
   logic [BYTE_W-1:0] rx_q;
   logic              tx_v_q;
   logic [BYTE_W-1:0] tx_b_q;
   logic              unused_inputs;

   assign unused_inputs = ^{bus_wdata, cnt_in};

   uart_irq_decode #(
      .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR),
      .MASK_ADDR(MASK_ADDR), .STAT_ADDR(STAT_ADDR)
   ) u_decode (
      .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .acc(acc)
   );

   uart_irq_status #(.IRQ_W(IRQ_W)) u_status (
      .clk(clk), .rst_n(rst_n), .acc(acc),
      .wbits(bus_wdata[IRQ_W-1:0]), .rx_strobe(rx_valid),
      .tick(cnt_in[CNT_TAP]), .status_q(status_q)
   );

   uart_irq_req #(.IRQ_W(IRQ_W), .REGISTERED(IRQ_REGISTERED)) u_req (
      .clk(clk), .rst_n(rst_n), .status(status_q), .mask(mask_q), .irq(irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         rx_q   <= '0;
         tx_v_q <= 1'b0;
         tx_b_q <= '0;
      end else begin
         if (acc.wr && acc.sel == SEL_MASK) mask_q <= bus_wdata[IRQ_W-1:0];
         if (rx_valid) rx_q <= rx_byte;
         tx_v_q <= acc.wr && (acc.sel == SEL_DATA);
         if (acc.wr && acc.sel == SEL_DATA) tx_b_q <= bus_wdata[BYTE_W-1:0];
      end
   end

   assign tx_valid = tx_v_q;
   assign tx_byte  = tx_b_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (acc.sel)
            SEL_DATA:   bus_rdata = {{BYTE_PAD{1'b0}}, rx_q};
            SEL_MASK:   bus_rdata = {{IRQ_PAD{1'b0}}, mask_q};
            SEL_STATUS: bus_rdata = {{IRQ_PAD{1'b0}}, status_q};
            default:    bus_rdata = '0;
         endcase
      end
   end

   AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DATA_ADDR) |=>
         tx_valid && tx_byte == $past(bus_wdata[BYTE_W-1:0])); // R7
   AST_TX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == DATA_ADDR) |=> !tx_valid); // R7
   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == MASK_ADDR) |=>
         mask_q == $past(bus_wdata[IRQ_W-1:0])); // R6
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr != DATA_ADDR && bus_addr != MASK_ADDR &&
       bus_addr != STAT_ADDR) |-> bus_rdata == '0); // R9
   AST_COLLIDE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_wr && bus_addr != STAT_ADDR && !rx_valid) |=>
         $stable(status_q[ST_TX_READY]) && $stable(status_q[ST_RX_AVAIL])); // R10

endmodule

// File: tb/uart_irq_regs_test.sv
`timescale 1ns/1ps
module uart_irq_regs_test;

   localparam logic [31:0] A_DATA = 32'h2000_0000;
   localparam logic [31:0] A_MASK = 32'h2000_0010;
   localparam logic [31:0] A_STAT = 32'h2000_0020;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        tx_valid;
   logic [7:0]  tx_byte;
   logic [31:0] cnt_in = '0;
   logic        irq;

   int checks = 0;
   int failures = 0;
   int tx_seen = 0;
   logic [31:0] rd_exp_q[$];
   string       rd_tag_q[$];
   logic [7:0]  tx_exp_q[$];

   always #4 clk = ~clk;

   uart_irq_regs uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_valid(tx_valid),
      .tx_byte(tx_byte), .cnt_in(cnt_in), .irq(irq)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // monitor: compare read data against scoreboard
   always @(negedge clk) begin
      #1;
      if (bus_rd && !bus_wr) begin
         if (rd_exp_q.size() == 0) check(1'b0, "read without expectation", bus_rdata, 0);
         else begin
            logic [31:0] e;
            string t;
            e = rd_exp_q.pop_front();
            t = rd_tag_q.pop_front();
            check(bus_rdata === e, t, bus_rdata, e);
         end
      end
      if (tx_valid) begin
         tx_seen++;
         if (tx_exp_q.size() == 0) check(1'b0, "R7 unexpected tx strobe", {24'b0, tx_byte}, 0);
         else begin
            logic [7:0] eb;
            eb = tx_exp_q.pop_front();
            check(tx_byte === eb, "R7 tx byte", {24'b0, tx_byte}, {24'b0, eb});
         end
      end
   end

   task automatic idle();
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0;
   endtask

   task automatic rd(input logic [31:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0; rx_valid = 1'b0;
      rd_exp_q.push_back(e); rd_tag_q.push_back(tag);
   endtask

   task automatic wr(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0; rx_valid = 1'b0;
      if (a == A_DATA) tx_exp_q.push_back(d[7:0]);
   endtask

   task automatic rx(input logic [7:0] b);
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0; rx_valid = 1'b1; rx_byte = b;
   endtask

   task automatic rd_with_rx(input logic [31:0] e, input logic [7:0] b, input string tag);
      @(negedge clk);
      bus_addr = A_DATA; bus_rd = 1'b1; bus_wr = 1'b0; rx_valid = 1'b1; rx_byte = b;
      rd_exp_q.push_back(e); rd_tag_q.push_back(tag);
   endtask

   task automatic rdwr_data(input logic [31:0] d);
      @(negedge clk);
      bus_addr = A_DATA; bus_wdata = d; bus_rd = 1'b1; bus_wr = 1'b1; rx_valid = 1'b0;
      tx_exp_q.push_back(d[7:0]);
   endtask

   task automatic chk_irq(input logic e, input string tag);
      #1;
      check(irq === e, tag, {31'b0, irq}, {31'b0, e});
   endtask

   initial begin
      #(8 * 20000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      chk_irq(1'b0, "R1 irq after reset");
      check(tx_valid === 1'b0, "R1 tx_valid after reset", {31'b0, tx_valid}, 0);
      rd(A_STAT, 32'h04, "R1 status after reset");
      rd(A_MASK, 32'h00, "R1 mask after reset");
      rd(A_DATA, 32'h00, "R1 data after reset");
      rd(A_STAT, 32'h06, "R4 read sets tx ready");

      wr(A_STAT, 32'h00);
      rd(A_STAT, 32'h04, "R6 status overwrite");
      wr(A_STAT, 32'hFF);
      rd(A_STAT, 32'hF7, "R5 counter bits override write");
      wr(A_STAT, 32'h00);
      cnt_in = 32'h1 << 18;
      idle();
      rd(A_STAT, 32'h08, "R5 counter tap high");
      rd(A_STAT, 32'h0A, "R4 tx ready after read");

      rx(8'hA5);
      rd(A_STAT, 32'h0B, "R2 rx sets avail");
      rd(A_DATA, 32'hA5, "R2 rx byte readback");
      rd(A_STAT, 32'h0A, "R3 data read clears avail");
      rd_with_rx(32'hA5, 8'h3C, "R3 old byte on collision");
      rd(A_STAT, 32'h0B, "R3 arrival wins over clear");
      rd(A_DATA, 32'h3C, "R2 new byte stored");
      rd(A_STAT, 32'h0A, "R3 cleared again");

      wr(A_MASK, 32'h01);
      idle(); idle();
      chk_irq(1'b0, "R8 masked-off status");
      rx(8'h11);
      idle();
      chk_irq(1'b0, "R8 irq one cycle late");
      idle();
      chk_irq(1'b1, "R8 irq asserted");
      rd(A_DATA, 32'h11, "R2 byte for irq");
      idle(); idle();
      chk_irq(1'b0, "R8 irq drops after read");
      rd(A_MASK, 32'h01, "R6 mask readback");

      wr(A_MASK, 32'h08);
      idle(); idle();
      chk_irq(1'b1, "R5 counter tap raises irq");
      cnt_in = 32'h0;
      idle(); idle(); idle();
      chk_irq(1'b0, "R5 counter tap low clears irq");

      wr(A_DATA, 32'h1234_56C3);
      wr(A_DATA, 32'h0000_005A);
      wr(A_DATA, 32'h0000_AB7E);
      idle(); idle();
      #1;
      check(tx_valid === 1'b0, "R7 strobe ends", {31'b0, tx_valid}, 0);
      check(tx_seen == 3, "R7 strobe count", tx_seen, 3);

      wr(32'h2000_0004, 32'hFF);
      rd(32'h2000_0004, 32'h0, "R9 unmapped read");
      rd(32'h1000_0000, 32'h0, "R9 far unmapped read");
      rd(32'h2000_0011, 32'h0, "R9 near-mask unmapped read");
      rd(A_MASK, 32'h08, "R9 mask untouched");
      rd(A_STAT, 32'h06, "R9 status untouched");

      wr(A_STAT, 32'h00);
      rx(8'h44);
      rdwr_data(32'h99);
      rd(A_STAT, 32'h05, "R10 no read side effect");
      rd(A_DATA, 32'h44, "R10 byte kept");
      idle(); idle();
      #1;
      check(tx_seen == 4, "R10 write performed", tx_seen, 4);
      check(rd_exp_q.size() == 0 && tx_exp_q.size() == 0, "scoreboard drained",
            rd_exp_q.size() + tx_exp_q.size(), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule